// File: doc/BRIEF.md
# Priority DMA Channel Bus Arbiter

The block decides which of eight DMA channels owns a shared bus master port. Every channel presents a request, a 3-bit priority value, a fill-mode lock flag and a pulse that marks the end of one transfer unit. A unit is either a single beat or a burst. The arbiter drives a one-hot grant vector, or all zeros when no channel is granted.

The decision has two keys. The larger priority value wins, where 0 is the lowest level and 7 the highest. If several channels share that value, the channel with the lower index wins. Once a channel holds the grant, the arbiter does not take it away until that channel finishes its unit. While the channel's fill-mode lock is high, the grant also survives unit boundaries, so a fill-mode block runs to its end without any other channel getting in.

Decisions are registered. The grant that results from a decision appears on the port one clock after the decision cycle. A decision is made in a cycle where no grant is held, or where the granted channel pulses its unit-done with its lock low.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, with no requests present, the grant vector is all zeros.
- R2: The grant vector never has more than one bit set.
- R3: With no grant held, a decision is made in every cycle. The chosen channel's bit is set one clock later. If no request is present, the grant stays all zeros.
- R4: At a decision, the requesting channel with the largest priority value wins. Each channel's 3-bit priority field sits at bits [3*i+2:3*i] of the priority bus, and 7 is the highest level.
- R5: Among requesters that share the largest priority value, the lowest channel index wins.
- R6: A held grant stays unchanged while the granted channel does not pulse unit-done, whatever other channels request and whatever priorities they present.
- R7: When the granted channel pulses unit-done with its lock low, a new decision is made in that cycle. The result appears one clock later, and the same channel may win again.
- R8: When the granted channel pulses unit-done with its lock high, the grant stays with that channel.
- R9: Priority values are only used in a decision cycle. Values presented while a grant is held have no effect on which channel wins later.
- R10: Unit-done pulses from channels that do not hold the grant have no effect on the grant.
- R11: If no channel requests at a decision made after a released grant, the grant becomes all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_req | input | NUM_CH | Per-channel bus request |
| ch_prio | input | NUM_CH*PRIO_W | Packed per-channel priority, channel i at [PRIO_W*i +: PRIO_W] |
| ch_fill_lock | input | NUM_CH | Per-channel fill-mode lock; holds the grant across unit boundaries |
| ch_unit_done | input | NUM_CH | Per-channel end-of-unit pulse (last beat of a burst or single beat) |
| bus_grant | output | NUM_CH | One-hot grant, all zeros when idle |

## Verification
A wrong held grant register shows up on `bus_grant` in the clock after the bad decision. It appears either as a second bit set or as a grant that moves while its owner has not finished a unit. An error in the priority comparison or the index tie-break only shows in a decision cycle. That is why the stimulus mixes equal-priority ties, top-level priorities on high-index channels and priority changes during held grants. A lock that is mishandled shows as a grant that leaves a fill-mode channel one clock after its unit-done pulse.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Ownership state of the shared master port
  typedef enum logic [0:0] {
    ARB_IDLE = 1'b0,
    ARB_HELD = 1'b1
  } arb_state_e;

endpackage

// File: rtl/dma_arb_pick.sv
// Combinational winner selection: highest priority value, lowest index on ties.
module dma_arb_pick #(
  parameter int NUM_CH = 8,
  parameter int PRIO_W = 3
) (
  input  logic [NUM_CH-1:0]        req,
  input  logic [NUM_CH*PRIO_W-1:0] prio,
  output logic [NUM_CH-1:0]        win_onehot,
  output logic                     win_valid
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  // Stage k holds the best candidate among channels k..NUM_CH-1
  logic [NUM_CH:0] found;
  logic [PRIO_W-1:0] best_prio [NUM_CH+1];
  logic [IDX_W-1:0]  best_idx  [NUM_CH+1];

  assign found[NUM_CH]     = 1'b0;
  assign best_prio[NUM_CH] = '0;
  assign best_idx[NUM_CH]  = '0;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_stage
    logic [PRIO_W-1:0] own_prio;
    logic              take;
    assign own_prio = prio[k*PRIO_W +: PRIO_W];
    // Lower index wins a tie, so equal priority replaces the higher-index candidate
    assign take = req[k] && (!found[k+1] || (own_prio >= best_prio[k+1]));
    assign found[k]     = found[k+1] | req[k];
    assign best_prio[k] = take ? own_prio : best_prio[k+1];
    assign best_idx[k]  = take ? IDX_W'(k) : best_idx[k+1];
  end

  assign win_valid  = found[0];
  assign win_onehot = found[0] ? ({{(NUM_CH-1){1'b0}}, 1'b1} << best_idx[0]) : '0;

  always_comb begin
    // R2
    pick_onehot_chk: assert ($onehot0(win_onehot));
    // R3
    pick_valid_chk: assert (win_valid == (|req));
  end

endmodule

// File: rtl/dma_arb_hold.sv
// Grant ownership register: decides when a new winner may be loaded.
module dma_arb_hold
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] win_onehot,
  input  logic              win_valid,
  input  logic [NUM_CH-1:0] unit_done,
  input  logic [NUM_CH-1:0] fill_lock,
  output logic [NUM_CH-1:0] grant
);

  arb_state_e        state_q, state_d;
  logic [NUM_CH-1:0] grant_q, grant_d;
  logic              owner_done, owner_locked, decide;

  assign owner_done   = |(grant_q & unit_done);
  assign owner_locked = |(grant_q & fill_lock);

  // Decision point: port free, or owner finished a unit outside a fill block
  assign decide = (state_q == ARB_IDLE) || (owner_done && !owner_locked);

  always_comb begin
    state_d = state_q;
    grant_d = grant_q;
    if (decide) begin
      grant_d = win_onehot;
      state_d = win_valid ? ARB_HELD : ARB_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
    end else if (decide) begin
      state_q <= state_d;
      grant_q <= grant_d;
    end
  end

  assign grant = grant_q;

  // R6
  hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_HELD && !owner_done) |=> $stable(grant_q));

  // R8
  fill_lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_HELD && owner_locked) |=> $stable(grant_q));

  // R1
  idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_IDLE) |-> (grant_q == '0));

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
  parameter int NUM_CH = 8,
  parameter int PRIO_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ch_req,
  input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
  input  logic [NUM_CH-1:0]        ch_fill_lock,
  input  logic [NUM_CH-1:0]        ch_unit_done,
  output logic [NUM_CH-1:0]        bus_grant
);

  logic [NUM_CH-1:0] win_onehot;
  logic              win_valid;

  dma_arb_pick #(
    .NUM_CH (NUM_CH),
    .PRIO_W (PRIO_W)
  ) u_pick (
    .req        (ch_req),
    .prio       (ch_prio),
    .win_onehot (win_onehot),
    .win_valid  (win_valid)
  );

  dma_arb_hold #(
    .NUM_CH (NUM_CH)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_onehot (win_onehot),
    .win_valid  (win_valid),
    .unit_done  (ch_unit_done),
    .fill_lock  (ch_fill_lock),
    .grant      (bus_grant)
  );

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_grant));

  // R3
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant == '0) |=> ((bus_grant == '0) || ((bus_grant & $past(ch_req)) != '0)));

  // R10
  foreign_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_grant != '0) && ((bus_grant & ch_unit_done) == '0)) |=> $stable(bus_grant));

  // R11
  release_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_grant & ch_unit_done & ~ch_fill_lock) != '0 && ch_req == '0) |=> (bus_grant == '0));

endmodule

// File: tb/tb_dma_bus_arbiter.sv
`timescale 1ns/1ps
module tb_dma_bus_arbiter;

  localparam int NCH = 8;
  localparam int PW  = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] req, lock, done;
  logic [NCH*PW-1:0] prio;
  logic [NCH-1:0] grant;
  logic [NCH-1:0] exp_grant;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_bus_arbiter #(.NUM_CH(NCH), .PRIO_W(PW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ch_req       (req),
    .ch_prio      (prio),
    .ch_fill_lock (lock),
    .ch_unit_done (done),
    .bus_grant    (grant)
  );

  function automatic logic [NCH-1:0] ref_pick(input logic [NCH-1:0] r,
                                              input logic [NCH*PW-1:0] p);
    int best = -1;
    int bp = -1;
    for (int i = 0; i < NCH; i++) begin
      if (r[i] && int'(p[i*PW +: PW]) > bp) begin
        bp = int'(p[i*PW +: PW]);
        best = i;
      end
    end
    return (best < 0) ? '0 : (NCH'(1) << best);
  endfunction

  function automatic logic [NCH-1:0] ref_next(input logic [NCH-1:0] g,
                                              input logic [NCH-1:0] r,
                                              input logic [NCH*PW-1:0] p,
                                              input logic [NCH-1:0] l,
                                              input logic [NCH-1:0] d);
    if (g == '0 || ((g & d) != '0 && (g & l) == '0)) return ref_pick(r, p);
    return g;
  endfunction

  function automatic logic [NCH*PW-1:0] setp(input logic [NCH*PW-1:0] v,
                                             input int ch, input int val);
    logic [NCH*PW-1:0] o = v;
    o[ch*PW +: PW] = PW'(val);
    return o;
  endfunction

  task automatic compare(input string tag);
    n_cmp++;
    if (grant !== exp_grant) begin
      n_bad++;
      $display("FAIL %s: grant=%b expected=%b at %0t", tag, grant, exp_grant, $time);
    end
    if (!$onehot0(grant)) begin
      n_bad++;
      $display("FAIL R2: grant=%b expected=one-hot or zero", grant);
    end
  endtask

  task automatic step(input logic [NCH-1:0] r, input logic [NCH*PW-1:0] p,
                      input logic [NCH-1:0] l, input logic [NCH-1:0] d,
                      input string tag);
    @(negedge clk);
    req = r; prio = p; lock = l; done = d;
    @(posedge clk);
    exp_grant = ref_next(exp_grant, r, p, l, d);
    #1;
    compare(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NCH*PW-1:0] p;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; req = '0; prio = '0; lock = '0; done = '0;
    exp_grant = '0;
    repeat (3) @(posedge clk);
    #1 compare("R1");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 compare("R1");

    // R4: channel 5 at priority 6 beats channel 2 at priority 3
    p = setp(setp('0, 2, 3), 5, 6);
    step(8'b0010_0100, p, '0, '0, "R4");
    // R5/R7: channel 5 finishes; channels 1 and 3 tie at 4, lower index wins
    p = setp(setp('0, 1, 4), 3, 4);
    step(8'b0000_1010, p, '0, 8'b0010_0000, "R5");
    // R6/R10: higher-priority requester and foreign done do not move the grant
    p = setp(setp('0, 1, 0), 7, 7);
    step(8'b1000_0010, p, '0, 8'b1000_0000, "R10");
    p = setp(setp('0, 1, 0), 6, 7);
    step(8'b0100_0010, p, '0, '0, "R6");
    // R9: at the decision channel 6 drops to 2, channel 4 presents 7
    p = setp(setp('0, 4, 7), 6, 2);
    step(8'b0101_0000, p, '0, 8'b0000_0010, "R9");
    // R8: locked owner keeps the port through a unit boundary
    p = setp(setp('0, 4, 7), 0, 7);
    step(8'b0001_0001, p, 8'b0001_0000, 8'b0001_0000, "R8");
    step(8'b0001_0001, p, 8'b0001_0000, 8'b0001_0000, "R8");
    // R7: lock released at done, channel 0 wins the tie at 7
    step(8'b0001_0001, p, '0, 8'b0001_0000, "R7");
    // R11: owner finishes with nobody requesting
    step('0, p, '0, 8'b0000_0001, "R11");
    step('0, p, '0, '0, "R3");
    step(8'b0000_1000, '0, '0, '0, "R3");
    // R7: same channel may win again at its own decision
    step(8'b0000_1000, '0, '0, 8'b0000_1000, "R7");

    // Random mix, priority sampled per cycle
    for (int n = 0; n < 4000; n++) begin
      logic [NCH-1:0] r, l, d;
      logic [NCH*PW-1:0] rp;
      r = NCH'($urandom);
      rp = (NCH*PW)'($urandom);
      l = NCH'($urandom) & NCH'($urandom);
      d = NCH'($urandom) & NCH'($urandom);
      step(r, rp, l, d, "R4 random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule